// File: doc/BRIEF.md
# Receive Ring Buffer DMA Sequencer

This block takes the byte stream of a frame being received and writes it into a ring of 256-byte pages in a local 16-bit memory. Incoming bytes wait in a small byte FIFO. When enough bytes have collected, the sequencer raises a bus request. Once granted, it writes a burst of 16-bit words. The first request of a frame waits until the whole 8-byte destination address field is buffered. Every later request is raised at a programmable word threshold.

At end of frame the sequencer keeps the bus. It finishes the current burst and drains the FIFO, padding an odd last byte to a full word. It then spends two internal preparation cycles and writes a two-word status header into the first four bytes of the frame's start page. Only after that does it release the request. The header carries a status byte, the page where the next frame will begin and the frame's stored byte count. Page addresses run from a ring start page up to, but not including, a ring stop page, and then wrap back to the start page.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, bus_req and mem_we are low. The first frame's page is the value of cfg_ring_start during reset.
- R2: The first bus request of a frame is raised only once 8 bytes of that frame are buffered, or once its last byte has arrived, whatever the threshold.
- R3: After the first burst of a frame, a new request is raised once at least 2×cfg_thresh_words bytes are buffered (legal values 1 to 4), or once the last byte has arrived. Each non-final burst writes cfg_thresh_words words; the first burst writes 4 words.
- R4: Frame data is written in arrival order as 16-bit words. The earlier byte goes in bits [7:0] and the later byte in bits [15:8]. The first data word goes to byte address {page, 8'h04}, and each following word goes 2 bytes higher.
- R5: When the next write address reaches {cfg_ring_stop, 8'h00}, it becomes {cfg_ring_start, 8'h00}, so every write lands in pages cfg_ring_start to cfg_ring_stop−1.
- R6: An odd final byte is written as a word with bits [15:8] equal to zero.
- R7: After the data, the sequencer writes {next_page, 8'h01} to {page, 8'h00}, then writes the frame length in bytes plus 4 to {page, 8'h02}. next_page is the page holding the next free address, rounded up to a page boundary and wrapped to cfg_ring_start if it equals cfg_ring_stop. The next frame starts at next_page.
- R8: Once a frame's last byte has arrived, bus_req does not fall until the second header word has been written.
- R9: The first header word is written exactly three cycles after the last data write, leaving two cycles without a write while the bus is held and granted.
- R10: Bytes presented without in_sof outside a frame, and bytes after in_eof, are neither stored nor written.
- R11: mem_we is only high while bus_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| cfg_thresh_words | input | 3 | Burst threshold in 16-bit words (1 to 4) |
| cfg_ring_start | input | 8 | First page of the ring |
| cfg_ring_stop | input | 8 | Page one past the end of the ring |
| bus_gnt | input | 1 | Memory bus granted |
| bus_req | output | 1 | Memory bus request |
| mem_addr | output | 16 | Byte address of the write |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write strobe |

## Verification
The assertions rely on several conditions on the inputs:
- A new frame starts only after the previous header has been written.
- cfg_ring_start is below cfg_ring_stop, and the threshold is between 1 and 4.
- The configuration stays fixed during a frame.
- The byte rate and the grant latency together never let the 16-byte FIFO overfill.

The stimulus keeps to these conditions in the following ways. The driver waits for each header before sending the next in_sof, and changes the threshold only between frames. For small thresholds it spaces bytes at least one idle cycle apart. It uses long grant delays only with the 4-word threshold and spaced bytes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BURST,
        ST_FLUSH,
        ST_PREP,
        ST_HDR0,
        ST_HDR1
    } dma_state_e;

    localparam int          FIRST_LEVEL   = 8;
    localparam int          PREP_CYCLES   = 2;
    localparam logic [7:0]  HDR_STATUS_OK = 8'h01;
    localparam logic [7:0]  DATA_OFFSET   = 8'h04;

    typedef struct packed {
        dma_state_e  state;
        logic        in_frame;
        logic        first_done;
        logic        eof_seen;
        logic [15:0] bcount;
        logic [7:0]  page;
        logic [15:0] wptr;
        logic [2:0]  burst_left;
        logic [1:0]  prep_cnt;
    } seq_regs_t;

    function automatic logic [15:0] ring_next(input logic [15:0] a,
                                              input logic [7:0]  lo_pg,
                                              input logic [7:0]  hi_pg);
        logic [15:0] n;
        n = a + 16'd2;
        if (n[7:0] == 8'h00 && n[15:8] == hi_pg) n = {lo_pg, 8'h00};
        return n;
    endfunction

endpackage

// File: rtl/rxd_byte_fifo.sv
module rxd_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [7:0]    push_data_i,
    input  logic [1:0]    pop_cnt_i,
    output logic [CW-1:0] fill_o,
    output logic [7:0]    head0_o,
    output logic [7:0]    head1_o
);

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] rd_d, rd_q, wr_d, wr_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        rd_d  = rd_q + AW'(pop_cnt_i);
        wr_d  = wr_q + AW'(push_i);
        cnt_d = cnt_q + CW'(push_i) - CW'(pop_cnt_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            rd_q  <= rd_d;
            wr_q  <= wr_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[wr_q] <= push_data_i;
    end

    assign fill_o  = cnt_q;
    assign head0_o = mem_q[rd_q];
    assign head1_o = mem_q[rd_q + AW'(1)];

    assert_fifo_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (cnt_q < CW'(DEPTH)) || (pop_cnt_i != 2'd0));

    assert_fifo_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        CW'(pop_cnt_i) <= cnt_q);

endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
    import rxd_pkg::*;
#(
    parameter int FILL_W = 5,
    parameter int THR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic              in_sof_i,
    input  logic              in_eof_i,
    input  logic [THR_W-1:0]  cfg_thresh_words_i,
    input  logic [7:0]        cfg_ring_start_i,
    input  logic [7:0]        cfg_ring_stop_i,
    input  logic              bus_gnt_i,
    input  logic [FILL_W-1:0] fifo_fill_i,
    input  logic [7:0]        head0_i,
    input  logic [7:0]        head1_i,
    output logic              push_o,
    output logic [1:0]        pop_cnt_o,
    output logic              bus_req_o,
    output logic [15:0]       mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    output logic              mem_we_o
);

    localparam seq_regs_t REGS_RST = '{state: ST_IDLE, in_frame: 1'b0, first_done: 1'b0,
                                       eof_seen: 1'b0, bcount: 16'd0, page: 8'd0,
                                       wptr: 16'd0, burst_left: 3'd0, prep_cnt: 2'd0};

    seq_regs_t        d, q;
    logic             start;
    logic [FILL_W-1:0] level;
    logic [7:0]       next_page;

    always_comb begin
        d           = q;
        pop_cnt_o   = 2'd0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.wptr;
        mem_wdata_o = {head1_i, head0_i};

        // frame intake
        start  = in_valid_i && in_sof_i && !q.in_frame && (q.state == ST_IDLE);
        push_o = start || (in_valid_i && q.in_frame && !q.eof_seen);
        if (start) begin
            d.in_frame   = 1'b1;
            d.first_done = 1'b0;
            d.eof_seen   = in_eof_i;
            d.bcount     = 16'd1;
            d.wptr       = {q.page, DATA_OFFSET};
        end else if (push_o) begin
            d.bcount = q.bcount + 16'd1;
            if (in_eof_i) d.eof_seen = 1'b1;
        end

        level = q.first_done ? FILL_W'({cfg_thresh_words_i, 1'b0}) : FILL_W'(FIRST_LEVEL);

        next_page = (q.wptr[7:0] == 8'h00) ? q.wptr[15:8] : q.wptr[15:8] + 8'd1;
        if (next_page == cfg_ring_stop_i) next_page = cfg_ring_start_i;

        case (q.state)
            ST_IDLE: begin
                if (q.in_frame && (q.eof_seen || fifo_fill_i >= level)) d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (bus_gnt_i) begin
                    d.first_done = 1'b1;
                    d.burst_left = 3'(level >> 1);
                    d.state      = d.eof_seen ? ST_FLUSH : ST_BURST;
                end
            end
            ST_BURST: begin
                if (bus_gnt_i) begin
                    mem_we_o     = 1'b1;
                    pop_cnt_o    = 2'd2;
                    d.wptr       = ring_next(q.wptr, cfg_ring_start_i, cfg_ring_stop_i);
                    d.burst_left = q.burst_left - 3'd1;
                    if (q.burst_left == 3'd1) d.state = d.eof_seen ? ST_FLUSH : ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (bus_gnt_i) begin
                    if (fifo_fill_i >= FILL_W'(2)) begin
                        mem_we_o  = 1'b1;
                        pop_cnt_o = 2'd2;
                        d.wptr    = ring_next(q.wptr, cfg_ring_start_i, cfg_ring_stop_i);
                    end else if (fifo_fill_i == FILL_W'(1)) begin
                        mem_we_o    = 1'b1;
                        pop_cnt_o   = 2'd1;
                        mem_wdata_o = {8'h00, head0_i};
                        d.wptr      = ring_next(q.wptr, cfg_ring_start_i, cfg_ring_stop_i);
                    end
                    if (fifo_fill_i <= FILL_W'(2)) begin
                        d.state    = ST_PREP;
                        d.prep_cnt = 2'(PREP_CYCLES - 1);
                    end
                end
            end
            ST_PREP: begin
                if (q.prep_cnt == 2'd0) d.state = ST_HDR0;
                else                    d.prep_cnt = q.prep_cnt - 2'd1;
            end
            ST_HDR0: begin
                mem_addr_o  = {q.page, 8'h00};
                mem_wdata_o = {next_page, HDR_STATUS_OK};
                if (bus_gnt_i) begin
                    mem_we_o = 1'b1;
                    d.state  = ST_HDR1;
                end
            end
            ST_HDR1: begin
                mem_addr_o  = {q.page, 8'h02};
                mem_wdata_o = q.bcount + 16'd4;
                if (bus_gnt_i) begin
                    mem_we_o   = 1'b1;
                    d.state    = ST_IDLE;
                    d.in_frame = 1'b0;
                    d.eof_seen = 1'b0;
                    d.page     = next_page;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q      <= REGS_RST;
            q.page <= cfg_ring_start_i;
        end else begin
            q <= d;
        end
    end

    assign bus_req_o = (q.state != ST_IDLE);

    assert_first_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(bus_req_o) && !q.first_done) |-> (q.eof_seen || $past(fifo_fill_i) >= FILL_W'(FIRST_LEVEL)));

    assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && q.eof_seen && q.state != ST_HDR1) |=> bus_req_o);

    assert_ring_bounds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> (mem_addr_o[15:8] >= cfg_ring_start_i && mem_addr_o[15:8] < cfg_ring_stop_i));

    assert_prep_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_HDR0 && $past(q.state) != ST_HDR0) |->
            ($past(q.state, 1) == ST_PREP && $past(q.state, 2) == ST_PREP));

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
    parameter int FIFO_DEPTH = 16,
    parameter int THR_W      = 3,
    localparam int FILL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [THR_W-1:0] cfg_thresh_words,
    input  logic [7:0]       cfg_ring_start,
    input  logic [7:0]       cfg_ring_stop,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic [15:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    output logic             mem_we
);

    logic              push;
    logic [1:0]        pop_cnt;
    logic [FILL_W-1:0] fill;
    logic [7:0]        head0, head1;

    rxd_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .push_i      (push),
        .push_data_i (in_data),
        .pop_cnt_i   (pop_cnt),
        .fill_o      (fill),
        .head0_o     (head0),
        .head1_o     (head1)
    );

    rxd_seq #(.FILL_W(FILL_W), .THR_W(THR_W)) u_seq (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .in_valid_i         (in_valid),
        .in_sof_i           (in_sof),
        .in_eof_i           (in_eof),
        .cfg_thresh_words_i (cfg_thresh_words),
        .cfg_ring_start_i   (cfg_ring_start),
        .cfg_ring_stop_i    (cfg_ring_stop),
        .bus_gnt_i          (bus_gnt),
        .fifo_fill_i        (fill),
        .head0_i            (head0),
        .head1_i            (head1),
        .push_o             (push),
        .pop_cnt_o          (pop_cnt),
        .bus_req_o          (bus_req),
        .mem_addr_o         (mem_addr),
        .mem_wdata_o        (mem_wdata),
        .mem_we_o           (mem_we)
    );

endmodule

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RING_LO = 8'h40;
    localparam logic [7:0] RING_HI = 8'h43;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [2:0]  cfg_thresh_words = 3'd1;
    logic [7:0]  cfg_ring_start = RING_LO;
    logic [7:0]  cfg_ring_stop = RING_HI;
    logic        bus_gnt = 1'b0;
    logic        bus_req;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_we;

    rx_ring_dma u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .cfg_thresh_words(cfg_thresh_words),
        .cfg_ring_start(cfg_ring_start), .cfg_ring_stop(cfg_ring_stop),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // kind: 0 data, 1 header word 0, 2 header word 1, 3 first word after wrap, 4 padded word
    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] data;
        logic [2:0]  kind;
        logic        odd;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   frames_done = 0;
    int   gnt_lat = 0;
    int   drv_bytes = 0;
    int   wr_bytes = 0;
    bit   eof_drv = 0;
    bit   hdr_done = 0;
    bit   first_rise = 0;
    logic [7:0] exp_page = RING_LO;

    // grant model: grant follows request after gnt_lat extra cycles
    int gwait = 0;
    always @(negedge clk) begin
        if (!rst_n || !bus_req) begin
            bus_gnt = 1'b0;
            gwait   = 0;
        end else if (gwait >= gnt_lat) begin
            bus_gnt = 1'b1;
        end else begin
            gwait++;
        end
    end

    function automatic logic [7:0] bytev(input logic [7:0] seed, input int i);
        return seed + 8'(i * 37);
    endfunction

    task automatic build_expected(input int len, input logic [7:0] seed);
        logic [15:0] a;
        logic [15:0] n;
        logic [7:0]  np;
        bit          wrapped;
        exp_t        e;
        a = {exp_page, 8'h04};
        wrapped = 0;
        for (int w = 0; w < (len + 1) / 2; w++) begin
            e.addr = a;
            e.odd  = len[0];
            if (2 * w + 1 >= len) begin
                e.data = {8'h00, bytev(seed, 2 * w)};
                e.kind = 3'd4;
            end else begin
                e.data = {bytev(seed, 2 * w + 1), bytev(seed, 2 * w)};
                e.kind = wrapped ? 3'd3 : 3'd0;
            end
            exp_q.push_back(e);
            n = a + 16'd2;
            wrapped = (n[7:0] == 8'h00 && n[15:8] == RING_HI);
            if (wrapped) n = {RING_LO, 8'h00};
            a = n;
        end
        np = (a[7:0] == 8'h00) ? a[15:8] : a[15:8] + 8'd1;
        if (np == RING_HI) np = RING_LO;
        exp_q.push_back('{addr: {exp_page, 8'h00}, data: {np, 8'h01}, kind: 3'd1, odd: len[0]});
        exp_q.push_back('{addr: {exp_page, 8'h02}, data: 16'(len + 4), kind: 3'd2, odd: len[0]});
        exp_page = np;
    endtask

    task automatic send_frame(input int len, input int gap, input logic [2:0] thr,
                              input int lat, input logic [7:0] seed);
        int target;
        @(negedge clk);
        cfg_thresh_words = thr;
        gnt_lat   = lat;
        drv_bytes = 0;
        wr_bytes  = 0;
        eof_drv   = 0;
        hdr_done  = 0;
        first_rise = 0;
        target = frames_done + 1;
        build_expected(len, seed);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = bytev(seed, i);
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            drv_bytes++;
            if (i == len - 1) eof_drv = 1;
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
            in_eof   = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        // bytes after the end of frame must be dropped (R10)
        in_valid = 1'b1;
        in_data  = 8'hEE;
        @(negedge clk);
        in_valid = 1'b0;
        wait (frames_done == target);
        repeat (2) @(negedge clk);
    endtask

    // monitor and scoreboard
    int   cyc = 0;
    int   last_we_cyc = 0;
    logic req_prev = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (rst_n) begin
                if (bus_req && !req_prev) begin
                    checks++;
                    if (!first_rise) begin
                        first_rise = 1;
                        if (!(drv_bytes - wr_bytes >= 8 || eof_drv)) begin
                            errors++;
                            $display("FAIL R2 first request with %0d bytes pending, expected >= 8", drv_bytes - wr_bytes);
                        end
                    end else if (!(drv_bytes - wr_bytes >= 2 * int'(cfg_thresh_words) || eof_drv)) begin
                        errors++;
                        $display("FAIL R3 request with %0d bytes pending, expected >= %0d",
                                 drv_bytes - wr_bytes, 2 * int'(cfg_thresh_words));
                    end
                end
                if (req_prev && !bus_req && eof_drv) begin
                    checks++;
                    if (!hdr_done) begin
                        errors++;
                        $display("FAIL R8 bus_req fell before header, got hdr_done=%0d expected 1", hdr_done);
                    end
                end
                if (mem_we) begin
                    checks++;
                    if (!bus_gnt) begin
                        errors++;
                        $display("FAIL R11 write with bus_gnt=%0b expected 1", bus_gnt);
                    end
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R10 unexpected write addr=%h data=%h, expected none", mem_addr, mem_wdata);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        checks++;
                        if (mem_addr !== e.addr || mem_wdata !== e.data) begin
                            errors++;
                            case (e.kind)
                                3'd1, 3'd2: $display("FAIL R7 header got %h:%h expected %h:%h", mem_addr, mem_wdata, e.addr, e.data);
                                3'd3:       $display("FAIL R5 wrap got %h:%h expected %h:%h", mem_addr, mem_wdata, e.addr, e.data);
                                3'd4:       $display("FAIL R6 padded word got %h:%h expected %h:%h", mem_addr, mem_wdata, e.addr, e.data);
                                default:    $display("FAIL R4 data got %h:%h expected %h:%h", mem_addr, mem_wdata, e.addr, e.data);
                            endcase
                        end
                        if (e.kind == 3'd1 && e.odd) begin
                            checks++;
                            if (cyc - last_we_cyc != 3) begin
                                errors++;
                                $display("FAIL R9 header gap %0d cycles expected 3", cyc - last_we_cyc);
                            end
                        end
                        if (e.kind == 3'd0 || e.kind == 3'd3) wr_bytes += 2;
                        if (e.kind == 3'd2) begin
                            hdr_done = 1;
                            frames_done++;
                        end
                    end
                    last_we_cyc = cyc;
                end
            end
            req_prev = bus_req;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, expected run to complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (bus_req !== 1'b0 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset bus_req=%b mem_we=%b expected 0 0", bus_req, mem_we);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (bus_req !== 1'b0 || mem_we !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset bus_req=%b mem_we=%b expected 0 0", bus_req, mem_we);
        end

        // R10: stray bytes with no start of frame
        for (int i = 0; i < 12; i++) begin
            in_valid = 1'b1;
            in_data  = 8'(i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        checks++;
        if (bus_req !== 1'b0) begin
            errors++;
            $display("FAIL R10 stray bytes raised bus_req=%b expected 0", bus_req);
        end

        send_frame(20, 1, 3'd1, 0, 8'h11);   // R2, R3, R4 small threshold
        send_frame(33, 0, 3'd4, 0, 8'h22);   // R6, R9 odd length, back-to-back bytes
        send_frame(1,  0, 3'd2, 0, 8'h33);   // single byte frame
        send_frame(7,  1, 3'd2, 0, 8'h44);   // ends before first level
        send_frame(41, 1, 3'd4, 3, 8'h55);   // slow grant, R11
        send_frame(300, 1, 3'd3, 1, 8'h66);  // R5 ring wrap
        send_frame(301, 1, 3'd3, 1, 8'h77);
        send_frame(300, 1, 3'd2, 1, 8'h88);

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 %0d expected writes missing, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule